// File: doc/BRIEF.md
# Tagged Integer Add Gate

The block stands between an operand source and the destination of an integer add. Each operand is a data word with a type tag beside it. The block examines both tags before the add is allowed to commit. When both operands are tagged as integers, the block delivers their sum, tagged as an integer, one clock after the request. When either operand is a placeholder for a pending asynchronous result, the block raises a future fault so that surrounding logic can suspend the thread. Any other non-integer tag raises an ordinary type trap. The fault outputs include a cause code that names the offending operand or operands.

The block takes one request per cycle and has no back-pressure. Its result register stands for the destination: it is written only by a successful add. Suspension and trap handling belong to the consumer of the fault strobes.

Top module: `tagged_add_gate`

## Requirements
- R1: While rst_ni is low, and after it is released, res_valid_o, fut_fault_o, type_trap_o, cause_o, res_data_o and res_tag_o are all zero until the first request.
- R2: A request (valid_i high at a rising edge) with both tags equal to 4'h0 (integer) sets res_valid_o high on the next cycle, with res_data_o = a_data_i + b_data_i and res_tag_o = 4'h0.
- R3: The integer sum wraps modulo 2^32, so the carry out of bit 31 is dropped.
- R4: A request in which either tag equals 4'hF (future) sets fut_fault_o high on the next cycle, with res_valid_o and type_trap_o low.
- R5: A request with no future tag but at least one tag in 4'h1..4'hE sets type_trap_o high on the next cycle, with res_valid_o and fut_fault_o low.
- R6: When one operand is a future and the other holds a different non-integer tag, only fut_fault_o is raised.
- R7: cause_o uses bit 0 for operand A and bit 1 for operand B (2'b01 A, 2'b10 B, 2'b11 both). It marks the operands whose tag matches the reported fault kind: future tags for a future fault, non-integer tags for a type trap. It is 2'b00 in any cycle without a fault.
- R8: On a faulting request, res_data_o and res_tag_o keep the values of the last successful add.
- R9: A cycle with valid_i low at the edge leaves res_valid_o, fut_fault_o and type_trap_o low on the next cycle, and res_data_o and res_tag_o unchanged.
- R10: At most one of res_valid_o, fut_fault_o and type_trap_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| a_data_i | input | 32 | Operand A data |
| a_tag_i | input | 4 | Operand A type tag |
| b_data_i | input | 32 | Operand B data |
| b_tag_i | input | 4 | Operand B type tag |
| res_valid_o | output | 1 | Sum committed this cycle |
| res_data_o | output | 32 | Destination data |
| res_tag_o | output | 4 | Destination tag |
| fut_fault_o | output | 1 | Future operand fault |
| type_trap_o | output | 1 | Non-integer operand trap |
| cause_o | output | 2 | Offending operand mask |

## Verification
Every request resolves in exactly one cycle, so a tag classified wrongly shows up at the ports on the cycle after the request: as the wrong strobe, as a sum where a fault was due, or as a cause bit on the wrong operand. A destination that the gate fails to protect shows up on the same cycle as a change in res_data_o after a fault. A missing priority shows up as a type trap where a future fault was due. The bench follows each request with a check of all outputs, so any error of this kind is reported on the cycle it appears.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned TAGW   = 4;
  localparam logic [TAGW-1:0] TAG_INT_DEF = 4'h0;
  localparam logic [TAGW-1:0] TAG_FUT_DEF = 4'hF;
  localparam int unsigned N_OPS = 2;
  // cause mask: bit0 = operand A, bit1 = operand B
  typedef logic [N_OPS-1:0] cause_t;
endpackage

// File: rtl/tag_classify.sv
module tag_classify #(
  parameter int unsigned TAG_W = 4,
  parameter logic [TAG_W-1:0] TAG_INT = '0,
  parameter logic [TAG_W-1:0] TAG_FUT = '1
) (
  input  logic [TAG_W-1:0] tag_i,
  output logic             is_fut_o,
  output logic             is_bad_o
);
  always_comb begin
    is_fut_o = (tag_i == TAG_FUT);
    is_bad_o = (tag_i != TAG_INT) && (tag_i != TAG_FUT);
  end
endmodule

// File: rtl/fault_resolve.sv
module fault_resolve
  import tagchk_pkg::*;
(
  input  cause_t fut_i,
  input  cause_t bad_i,
  output logic   ok_o,
  output logic   fut_o,
  output logic   trap_o,
  output cause_t cause_o
);
  always_comb begin
    fut_o   = |fut_i;
    trap_o  = !fut_o && (|bad_i);   // future wins
    ok_o    = !fut_o && !trap_o;
    if (fut_o)       cause_o = fut_i;
    else if (trap_o) cause_o = bad_i;
    else             cause_o = '0;
  end
endmodule

// File: rtl/wrap_adder.sv
module wrap_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  logic [W:0] full;
  logic       carry_unused;
  always_comb begin
    full         = {1'b0, a_i} + {1'b0, b_i};
    sum_o        = full[W-1:0];
    carry_unused = full[W];
  end
endmodule

// File: rtl/tagged_add_gate.sv
module tagged_add_gate
  import tagchk_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned TAG_W  = TAGW,
  parameter logic [TAG_W-1:0] TAG_INT = TAG_INT_DEF,
  parameter logic [TAG_W-1:0] TAG_FUT = TAG_FUT_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic [TAG_W-1:0]  a_tag_i,
  input  logic [DATA_W-1:0] b_data_i,
  input  logic [TAG_W-1:0]  b_tag_i,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic [TAG_W-1:0]  res_tag_o,
  output logic              fut_fault_o,
  output logic              type_trap_o,
  output logic [1:0]        cause_o
);
  logic [N_OPS-1:0][TAG_W-1:0] tags;
  cause_t fut_v, bad_v, cause_d;
  logic   ok_d, fut_d, trap_d;
  logic [DATA_W-1:0] sum_d;

  assign tags[0] = a_tag_i;
  assign tags[1] = b_tag_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    tag_classify #(.TAG_W(TAG_W), .TAG_INT(TAG_INT), .TAG_FUT(TAG_FUT)) i_cls (
      .tag_i   (tags[g]),
      .is_fut_o(fut_v[g]),
      .is_bad_o(bad_v[g])
    );
  end

  fault_resolve i_res (
    .fut_i  (fut_v),
    .bad_i  (bad_v),
    .ok_o   (ok_d),
    .fut_o  (fut_d),
    .trap_o (trap_d),
    .cause_o(cause_d)
  );

  wrap_adder #(.W(DATA_W)) i_add (
    .a_i  (a_data_i),
    .b_i  (b_data_i),
    .sum_o(sum_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      fut_fault_o <= 1'b0;
      type_trap_o <= 1'b0;
      cause_o     <= '0;
    end else begin
      res_valid_o <= valid_i && ok_d;
      fut_fault_o <= valid_i && fut_d;
      type_trap_o <= valid_i && trap_d;
      cause_o     <= valid_i ? cause_d : '0;
    end
  end

  // destination: written only by a committed add
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_data_o <= '0;
      res_tag_o  <= '0;
    end else if (valid_i && ok_d) begin
      res_data_o <= sum_d;
      res_tag_o  <= TAG_INT;
    end
  end

  // R10
  one_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({res_valid_o, fut_fault_o, type_trap_o}));

  // R2
  int_tag_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> res_tag_o == TAG_INT);

  // R8
  dest_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fut_fault_o || type_trap_o) |-> $stable(res_data_o) && $stable(res_tag_o));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !res_valid_o && !fut_fault_o && !type_trap_o);

  // R7
  cause_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o != 2'b00) == (fut_fault_o || type_trap_o));

  // R6
  fut_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (a_tag_i == TAG_FUT || b_tag_i == TAG_FUT) |=> fut_fault_o && !type_trap_o);
endmodule

// File: tb/test_tagged_add_gate.sv
module test_tagged_add_gate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] a_data_i = '0, b_data_i = '0;
  logic [3:0]  a_tag_i = '0, b_tag_i = '0;
  logic        res_valid_o, fut_fault_o, type_trap_o;
  logic [31:0] res_data_o;
  logic [3:0]  res_tag_o;
  logic [1:0]  cause_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_data = '0;
  logic [3:0]  exp_tag = '0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  tagged_add_gate i_tagged_add_gate (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_cause(input logic [3:0] ta, input logic [3:0] tb, output bit fut, output bit trap);
    logic [1:0] fm, bm;
    fm = {tb == 4'hF, ta == 4'hF};
    bm = {tb != 4'h0 && tb != 4'hF, ta != 4'h0 && ta != 4'hF};
    fut  = |fm;
    trap = !fut && |bm;
    return fut ? fm : (trap ? bm : 2'b00);
  endfunction

  task automatic op(input bit v, input logic [31:0] a, input logic [3:0] ta,
                    input logic [31:0] b, input logic [3:0] tb, input string req);
    bit ef, et, ev;
    logic [1:0] ec;
    @(negedge clk_i);
    valid_i = v; a_data_i = a; a_tag_i = ta; b_data_i = b; b_tag_i = tb;
    ec = ref_cause(ta, tb, ef, et);
    ev = v && !ef && !et;
    if (!v) begin ef = 0; et = 0; ec = 0; end
    if (ev) begin exp_data = a + b; exp_tag = 4'h0; end
    @(negedge clk_i);
    valid_i = 1'b0;
    check({res_valid_o, fut_fault_o, type_trap_o} == {ev, ef, et}, {req, " strobes"},
          {61'd0, res_valid_o, fut_fault_o, type_trap_o}, {61'd0, ev, ef, et});
    check(cause_o == ec, {req, " R7 cause"}, {62'd0, cause_o}, {62'd0, ec});
    check(res_data_o == exp_data && res_tag_o == exp_tag, {req, " R8 dest"},
          {28'd0, res_tag_o, res_data_o}, {28'd0, exp_tag, exp_data});
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #7;
    // R1
    check({res_valid_o, fut_fault_o, type_trap_o, cause_o, res_data_o, res_tag_o} == '0,
          "R1 in reset", {20'd0, res_data_o, res_tag_o}, 64'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check({res_valid_o, fut_fault_o, type_trap_o, cause_o, res_data_o, res_tag_o} == '0,
          "R1 after reset", {20'd0, res_data_o, res_tag_o}, 64'd0);
    op(1, 32'd5, 4'h0, 32'd7, 4'h0, "R2 int add");
    op(1, 32'hFFFF_FFFF, 4'h0, 32'd2, 4'h0, "R3 wrap");
    op(1, 32'h8000_0000, 4'h0, 32'h8000_0000, 4'h0, "R3 wrap zero");
    op(1, 32'd1, 4'hF, 32'd2, 4'h0, "R4 fut A");
    op(1, 32'd1, 4'h0, 32'd2, 4'hF, "R4 fut B");
    op(1, 32'd1, 4'hF, 32'd2, 4'hF, "R4 fut AB");
    op(1, 32'd9, 4'h3, 32'd2, 4'h0, "R5 trap A");
    op(1, 32'd9, 4'h0, 32'd2, 4'hE, "R5 trap B");
    op(1, 32'd9, 4'h1, 32'd2, 4'h7, "R5 trap AB");
    op(1, 32'd9, 4'hF, 32'd2, 4'h4, "R6 fut A bad B");
    op(1, 32'd9, 4'h2, 32'd2, 4'hF, "R6 bad A fut B");
    op(0, 32'd100, 4'h0, 32'd100, 4'h0, "R9 idle");
    op(1, 32'd10, 4'h0, 32'd20, 4'h0, "R2 int add 2");
    op(0, 32'd1, 4'hF, 32'd1, 4'h5, "R9 idle bad tags");
    for (int i = 0; i < 400; i++) begin
      logic [3:0] ta, tb;
      int s;
      s = $urandom_range(0, 9);
      ta = (s < 5) ? 4'h0 : (s < 7) ? 4'hF : 4'($urandom_range(1, 14));
      s = $urandom_range(0, 9);
      tb = (s < 5) ? 4'h0 : (s < 7) ? 4'hF : 4'($urandom_range(1, 14));
      op($urandom_range(0, 7) != 0, $urandom, ta, $urandom, tb, "R10 random");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule